// File: doc/BRIEF.md
# Interrupt Status Aggregator with Dual Delivery

This block gathers interrupt causes into one status word and signals them to the host in one of two ways. When the message-signalled mode input is low, it drives a level-sensitive legacy interrupt line. When that input is high, it emits a one-cycle message request for each qualifying raise event. Two internal completion sources set fixed status bits through single-cycle pulses. Software can inject interrupts by writing a raise offset and can retire them by writing an acknowledge offset. It reads the status word back through a combinational read port.

Delivery is handled by a small state machine with three states:

- `DLV_LINE_IDLE`: legacy mode, line low.
- `DLV_LINE_ACTIVE`: legacy mode, line high.
- `DLV_MSG_MODE`: message mode, line held low.

Its transitions are:

- **enter-message**: from any state to `DLV_MSG_MODE` whenever the mode input is high.
- **assert-line**: from `DLV_LINE_IDLE`, or from `DLV_MSG_MODE` with the mode input low, to `DLV_LINE_ACTIVE` on a raise event that leaves the status nonzero.
- **release-line**: from `DLV_LINE_ACTIVE` to `DLV_LINE_IDLE` on an acknowledge that leaves the status zero.
- **leave-message**: from `DLV_MSG_MODE` to `DLV_LINE_IDLE` when the mode input is low and no assert-line condition holds.

A raise event is any cycle with a completion pulse or a write to the raise offset. An acknowledge event is a write to the acknowledge offset.

Top module: `irq_collector`

## Requirements
- R1: After reset the status word is zero and both the legacy line and the message request are low.
- R2: A pulse on `compute_done` sets status bit 0 and a pulse on `dma_done` sets status bit 8, visible from the next clock edge.
- R3: A read at offset 0x24 returns the status word; a read at any other offset returns zero.
- R4: A write at offset 0x60 ORs the write data into the status word.
- R5: A write at offset 0x64 clears each status bit that is 1 in the write data and leaves the others.
- R6: When a completion pulse and an acknowledge hit the same bit in the same cycle, the bit ends set.
- R7: With message mode off, the legacy line is high from the edge after any raise event that leaves the status nonzero, including a raise of zero data onto a nonzero status; a raise that leaves the status zero keeps it low.
- R8: With message mode off, the line falls at the edge after an acknowledge that leaves the status zero, and stays high after an acknowledge that leaves it nonzero.
- R9: With message mode on, each raise event that leaves the status nonzero produces exactly one one-cycle `msi_req` pulse at the next edge; raise events in consecutive cycles produce consecutive pulses.
- R10: With message mode on, acknowledges never produce a request, and a raise that leaves the status zero produces none either.
- R11: One edge after `msi_en` is high the legacy line is low. Returning to legacy mode keeps the line low until the next qualifying raise, even with status pending.
- R12: Writes at offsets other than 0x60 and 0x64 change neither the status word nor the legacy line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Selects message delivery (1) or legacy line (0) |
| compute_done | input | 1 | Single-cycle pulse, sets status bit 0 |
| dma_done | input | 1 | Single-cycle pulse, sets status bit 8 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | STAT_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | STAT_W | Read data (status at 0x24, else zero) |
| intx_level | output | 1 | Legacy level-sensitive interrupt line |
| msi_req | output | 1 | One-cycle message request pulse |

## Verification
The bench builds the block with its defaults: a 32-bit status word and an 8-bit offset space. This makes every status bit and every write offset reachable in short sweeps.

Each status bit is raised and acknowledged alone, which exercises assert-line and release-line for every bit. All 256 write offsets are swept against a pending status to show that only the two active offsets have any effect. All 256 read offsets are compared with the modelled status.

Mode switches are driven with status pending, with consecutive raises, and with completion pulses that coincide with acknowledges. Each output is compared cycle by cycle against an arithmetic model of the status word and the delivery state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        DLV_LINE_IDLE   = 2'd0,
        DLV_LINE_ACTIVE = 2'd1,
        DLV_MSG_MODE    = 2'd2
    } dlv_state_e;

    localparam int unsigned IRQC_OFS_STATUS = 'h24;
    localparam int unsigned IRQC_OFS_RAISE  = 'h60;
    localparam int unsigned IRQC_OFS_ACK    = 'h64;

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STAT_W     = 32,
    parameter int unsigned OFS_STATUS = irqc_pkg::IRQC_OFS_STATUS,
    parameter int unsigned OFS_RAISE  = irqc_pkg::IRQC_OFS_RAISE,
    parameter int unsigned OFS_ACK    = irqc_pkg::IRQC_OFS_ACK
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [STAT_W-1:0] status,
    output logic              sw_raise,
    output logic              sw_ack,
    output logic [STAT_W-1:0] sw_raise_mask,
    output logic [STAT_W-1:0] sw_ack_mask,
    output logic [STAT_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

    always_comb begin
        sw_raise      = wr_en && (wr_addr == A_RAISE);
        sw_ack        = wr_en && (wr_addr == A_ACK);
        sw_raise_mask = sw_raise ? wr_data : '0;
        sw_ack_mask   = sw_ack   ? wr_data : '0;
        rd_data       = (rd_addr == A_STATUS) ? status : '0;
    end

endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg #(
    parameter int unsigned STAT_W      = 32,
    parameter int unsigned BIT_COMPUTE = 0,
    parameter int unsigned BIT_DMA     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              compute_done,
    input  logic              dma_done,
    input  logic              sw_raise,
    input  logic [STAT_W-1:0] sw_raise_mask,
    input  logic              sw_ack,
    input  logic [STAT_W-1:0] sw_ack_mask,
    output logic [STAT_W-1:0] status_q,
    output logic              raise_evt,
    output logic              nx_nonzero
);
    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] status_nx;

    // Map each completion source onto its fixed status position.
    for (genvar g = 0; g < STAT_W; g++) begin : g_src_map
        assign hw_set[g] = ((g == BIT_COMPUTE) && compute_done) ||
                           ((g == BIT_DMA)     && dma_done);
    end

    always_comb begin
        // Clear first, then set: a bit hit by both ends set.
        status_nx  = (status_q & ~sw_ack_mask) | hw_set | sw_raise_mask;
        raise_evt  = compute_done || dma_done || sw_raise;
        nx_nonzero = |status_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nx;
    end

    // R6: a completion pulse always wins over a same-cycle acknowledge.
    a_r6_set_over_ack: assert property (@(posedge clk) disable iff (!rst_n)
        compute_done |=> status_q[BIT_COMPUTE]);

    // R5: an acknowledge without a concurrent set leaves the acked bits clear.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ack && !compute_done && !dma_done) |=>
            ((status_q & $past(sw_ack_mask)) == '0));

endmodule

// File: rtl/irqc_delivery_fsm.sv
module irqc_delivery_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msi_en,
    input  logic raise_evt,
    input  logic ack_evt,
    input  logic nx_nonzero,
    output logic line_o,
    output logic msi_req_o
);
    dlv_state_e state_q, state_nx;
    logic       qualify_raise;

    assign qualify_raise = raise_evt && nx_nonzero;

    always_comb begin
        state_nx = state_q;
        if (msi_en) begin
            state_nx = DLV_MSG_MODE;                       // enter-message
        end else begin
            unique case (state_q)
                DLV_LINE_IDLE:
                    if (qualify_raise) state_nx = DLV_LINE_ACTIVE;   // assert-line
                DLV_LINE_ACTIVE:
                    if (ack_evt && !nx_nonzero) state_nx = DLV_LINE_IDLE; // release-line
                DLV_MSG_MODE:
                    state_nx = qualify_raise ? DLV_LINE_ACTIVE      // assert-line
                                             : DLV_LINE_IDLE;       // leave-message
                default:
                    state_nx = DLV_LINE_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DLV_LINE_IDLE;
        else        state_q <= state_nx;
    end

    // Outputs: the line follows the state; the request is a registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) msi_req_o <= 1'b0;
        else        msi_req_o <= msi_en && qualify_raise;
    end

    assign line_o = (state_q == DLV_LINE_ACTIVE);

    // R11: message mode forces the legacy line low one edge later.
    a_r11_msi_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |=> !line_o);

    // R10: an acknowledge with no raise never yields a request.
    a_r10_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_evt && !raise_evt) |=> !msi_req_o);

    // R9: a request is only issued when message mode was selected.
    a_r9_req_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |=> !msi_req_o);

endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned STAT_W      = 32,
    parameter int unsigned BIT_COMPUTE = 0,
    parameter int unsigned BIT_DMA     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic              compute_done,
    input  logic              dma_done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [STAT_W-1:0] rd_data,
    output logic              intx_level,
    output logic              msi_req
);
    logic              sw_raise, sw_ack;
    logic [STAT_W-1:0] sw_raise_mask, sw_ack_mask;
    logic [STAT_W-1:0] status_q;
    logic              raise_evt, nx_nonzero;

    irqc_bus_decode #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_decode (
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .status        (status_q),
        .sw_raise      (sw_raise),
        .sw_ack        (sw_ack),
        .sw_raise_mask (sw_raise_mask),
        .sw_ack_mask   (sw_ack_mask),
        .rd_data       (rd_data)
    );

    irqc_status_reg #(.STAT_W(STAT_W), .BIT_COMPUTE(BIT_COMPUTE), .BIT_DMA(BIT_DMA)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .compute_done  (compute_done),
        .dma_done      (dma_done),
        .sw_raise      (sw_raise),
        .sw_raise_mask (sw_raise_mask),
        .sw_ack        (sw_ack),
        .sw_ack_mask   (sw_ack_mask),
        .status_q      (status_q),
        .raise_evt     (raise_evt),
        .nx_nonzero    (nx_nonzero)
    );

    irqc_delivery_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .msi_en     (msi_en),
        .raise_evt  (raise_evt),
        .ack_evt    (sw_ack),
        .nx_nonzero (nx_nonzero),
        .line_o     (intx_level),
        .msi_req_o  (msi_req)
    );

    // R7: the legacy line is never high while nothing is pending.
    a_r7_line_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
        intx_level |-> (status_q != '0));

    // R9: every request coincides with a nonzero status word.
    a_r9_req_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> (status_q != '0));

    // R12: an unmapped write with no completion pulse leaves status untouched.
    a_r12_other_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sw_raise && !sw_ack && !compute_done && !dma_done) |=>
            $stable(status_q));

endmodule

// File: tb/irq_collector_tb.sv
module irq_collector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_en = 1'b0;
    logic        compute_done = 1'b0;
    logic        dma_done = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h24;
    logic [31:0] rd_data;
    logic        intx_level;
    logic        msi_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_stat = '0;
    logic        m_line = 1'b0;
    logic        m_msg  = 1'b0;

    always #4 clk = ~clk;

    irq_collector u_dut (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en),
        .compute_done(compute_done), .dma_done(dma_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .intx_level(intx_level), .msi_req(msi_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one cycle of stimulus (called at a falling edge), waits for the
    // next falling edge and compares all outputs with the model.
    task automatic apply(string tag, logic msi, logic cd, logic dd,
                         logic we, logic [7:0] a, logic [31:0] d);
        logic [31:0] set, clr, nx;
        logic raise, ack, e_msi, e_line;
        set   = ((we && a == 8'h60) ? d : 32'h0) | (cd ? 32'h1 : 32'h0) | (dd ? 32'h100 : 32'h0);
        clr   = (we && a == 8'h64) ? d : 32'h0;
        nx    = (m_stat & ~clr) | set;
        raise = cd || dd || (we && a == 8'h60);
        ack   = we && a == 8'h64;
        e_msi = msi && raise && (nx != 0);
        if (msi)         e_line = 1'b0;
        else if (m_msg)  e_line = raise && (nx != 0);
        else if (m_line) e_line = !(ack && (nx == 0));
        else             e_line = raise && (nx != 0);
        msi_en = msi; compute_done = cd; dma_done = dd;
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = 8'h24;
        @(negedge clk);
        m_stat = nx; m_line = e_line; m_msg = msi;
        chk({tag, " status"}, rd_data, m_stat);
        chk({tag, " line"}, {31'h0, intx_level}, {31'h0, m_line});
        chk({tag, " msi_req"}, {31'h0, msi_req}, {31'h0, e_msi});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 status", rd_data, 32'h0);
        chk("R1 line", {31'h0, intx_level}, 32'h0);
        chk("R1 msi_req", {31'h0, msi_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5/R7/R8: every bit raised alone then acknowledged alone (legacy)
        for (int i = 0; i < 32; i++) begin
            apply("R7 R4 raise bit", 0, 0, 0, 1, 8'h60, 32'h1 << i);
            apply("R8 R5 ack bit",   0, 0, 0, 1, 8'h64, 32'h1 << i);
        end
        // R7: raise of zero onto zero status keeps line low
        apply("R7 zero raise", 0, 0, 0, 1, 8'h60, 32'h0);
        // R4: OR accumulation
        apply("R4 or a", 0, 0, 0, 1, 8'h60, 32'h0000_00F0);
        apply("R4 or b", 0, 0, 0, 1, 8'h60, 32'h0F00_0030);
        // R8: partial ack keeps line, full ack drops it
        apply("R8 partial ack", 0, 0, 0, 1, 8'h64, 32'h0000_0030);
        apply("R5 ack nonset", 0, 0, 0, 1, 8'h64, 32'hF000_0000);
        apply("R8 full ack", 0, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);

        // R2: completion pulses set bits 0 and 8
        apply("R2 compute", 0, 1, 0, 0, 8'h00, 32'h0);
        apply("R2 idle", 0, 0, 0, 0, 8'h00, 32'h0);
        apply("R2 dma", 0, 0, 1, 0, 8'h00, 32'h0);
        apply("R8 clear", 0, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);
        apply("R2 both", 0, 1, 1, 0, 8'h00, 32'h0);
        apply("R8 clear2", 0, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);

        // R6: set beats a same-cycle ack
        apply("R6 compute vs ack", 0, 1, 0, 1, 8'h64, 32'h0000_0001);
        apply("R6 dma vs ack all", 0, 0, 1, 1, 8'h64, 32'hFFFF_FFFF);
        apply("R6 clear", 0, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);

        // R12: sweep every other write offset with status pending
        apply("R12 prep", 0, 0, 0, 1, 8'h60, 32'h0000_0005);
        for (int a = 0; a < 256; a++) begin
            if (a != 'h60 && a != 'h64)
                apply("R12 other offset", 0, 0, 0, 1, 8'(a), 32'hFFFF_FFFF);
        end
        apply("R7 zero raise pending", 0, 0, 0, 1, 8'h60, 32'h0);
        apply("R12 idle", 0, 0, 0, 0, 8'h00, 32'h0);

        // R3: read offset sweep
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #1;
            chk("R3 read", rd_data, (a == 'h24) ? m_stat : 32'h0);
        end
        @(negedge clk);

        // R11: enabling message mode drops a high line
        apply("R11 enable", 1, 0, 0, 0, 8'h00, 32'h0);
        // R9: consecutive raises each pulse, idle gives none
        apply("R9 raise 1", 1, 0, 0, 1, 8'h60, 32'h0000_0100);
        apply("R9 raise 2", 1, 1, 0, 0, 8'h00, 32'h0);
        apply("R9 raise 3", 1, 0, 0, 1, 8'h60, 32'h0);
        apply("R9 idle", 1, 0, 0, 0, 8'h00, 32'h0);
        apply("R9 dma", 1, 0, 1, 0, 8'h00, 32'h0);
        // R10: acks are silent
        apply("R10 partial ack", 1, 0, 0, 1, 8'h64, 32'h0000_0001);
        apply("R10 full ack", 1, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);
        apply("R10 zero raise", 1, 0, 0, 1, 8'h60, 32'h0);
        apply("R6 msi set vs ack", 1, 1, 0, 1, 8'h64, 32'h0000_0001);

        // R11: back to legacy with status pending, line stays low until a raise
        apply("R11 leave", 0, 0, 0, 0, 8'h00, 32'h0);
        apply("R11 still low", 0, 0, 0, 0, 8'h00, 32'h0);
        apply("R11 raise", 0, 0, 0, 1, 8'h60, 32'h0);
        apply("R11 to msi", 1, 0, 0, 0, 8'h00, 32'h0);
        apply("R11 leave raise", 0, 0, 1, 0, 8'h00, 32'h0);
        apply("R8 final ack", 0, 0, 0, 1, 8'h64, 32'hFFFF_FFFF);
        apply("R1 idle", 0, 0, 0, 0, 8'h00, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule